// File: doc/BRIEF.md
# Receive Descriptor Drain Engine

This block empties a word-wide receive FIFO into host memory. It follows a chain of receive descriptors, each three words long: a link word at offset 0, a control/status word at offset 4 and a buffer address at offset 8. It holds one descriptor in a local cache. When enough data has collected, it writes the frame into the descriptor's buffer one 32-bit word at a time. It then writes a status word back over the control word and moves on to the next descriptor in the chain.

A frame that does not fit in one buffer continues into the buffers of the following descriptors. Each of those descriptors is closed with a continuation flag. Every host access is a request held steady until a one-cycle done pulse arrives. Software starts the engine with a one-cycle command. A dirty flag tells the engine that the descriptor at the head pointer has already been used, so it skips to that descriptor's link.

Descriptor control word as read: bit 31 set means the buffer is free for the device, and bits 11:0 give the buffer size in bytes, a multiple of 4. Status word as written back: bit 31 clear, bit 30 set when the frame continues in the next buffer, bits 29:12 zero, and bits 11:0 the number of bytes stored in this buffer.

Top module: `rx_drain_dma`

## Requirements
- R1: After reset the engine is idle: `idle`=1, `bus_req`=0 and `fifo_pop`=0.
- R2: A start command in idle with `desc_dirty`=0 reads the head descriptor at head+0, +4 and +8, in that order. With `desc_dirty`=1 it reads only head+0 and then reads the descriptor that this link points to.
- R3: A descriptor whose control bit 31 is clear sends the engine back to idle, with no write to host memory.
- R4: Data moves only while `fifo_words` is non-zero and either `fifo_words` ≥ 2×`cfg_thr` (the threshold counts 8-byte units) or `fifo_frame_ready` is set. While those conditions are not met, no data is written.
- R5: The number of words moved in one burst is bounded by `cfg_burst`. Code 0 allows 128 words and code k (1..7) allows 2^(k-1) words. Between bursts `bus_req` drops for at least one cycle, while words continue back to back within a burst.
- R6: Frame words are written in order to buffer+4·i. A request keeps its address and direction until `bus_done`, and a FIFO word is popped exactly when its write completes.
- R7: When a buffer fills before the frame ends, the status written at descriptor+4 has bit 30 set and a size equal to the buffer size. The frame then continues in the next descriptor's buffer.
- R8: At the end of the frame the status has bit 30 clear and a size of 4·(n−1)+`fifo_last_bytes` for the n words held in that buffer. `fifo_last_bytes` is coded 1..4.
- R9: After each status write, a non-zero link makes the engine read the next descriptor, where the next frame lands. A zero link returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en_cmd | input | 1 | One-cycle start command |
| desc_dirty | input | 1 | Head descriptor already consumed |
| desc_head | input | AW | Address of the head descriptor |
| cfg_thr | input | THW | Drain threshold in 8-byte units |
| cfg_burst | input | 3 | Coded maximum burst length |
| fifo_words | input | FWW | Words held in the FIFO |
| fifo_frame_ready | input | 1 | FIFO holds the end of a frame |
| fifo_data | input | 32 | FIFO head word |
| fifo_last | input | 1 | Head word ends the frame |
| fifo_last_bytes | input | 3 | Valid bytes in the final word, 1..4 |
| fifo_pop | output | 1 | Remove the head word |
| bus_req | output | 1 | Host access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with done |
| bus_done | input | 1 | Access completes |
| idle | output | 1 | Engine waiting for a command |

## Verification
The assertions assume three things about the host side: `bus_done` pulses for one cycle only while a request is pending, `fifo_words` counts exactly the words the FIFO holds, and `fifo_data` shows the head word ahead of the pop. The bench's host model pulses done one cycle after it sees a request. Its FIFO model removes a word only on the pop that follows a completed data write. Buffer sizes are always multiples of four, and `fifo_last` is raised only on the final pushed word of a frame.

// File: rtl/rxdd_pkg.sv
package rxdd_pkg;
  localparam int SZW = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_REFRESH, S_DREAD, S_BLOCK, S_FRAG, S_DWRITE, S_ADV
  } rxdd_state_e;

  // words allowed per burst for a 3-bit code
  function automatic logic [7:0] burst_limit(input logic [2:0] code);
    return (code == 3'd0) ? 8'd128 : (8'd1 << (code - 3'd1));
  endfunction

  // status written back over the control word
  function automatic logic [31:0] wb_word(input logic more, input logic [SZW-1:0] size);
    return {1'b0, more, 18'b0, size};
  endfunction
endpackage

// File: rtl/rxdd_trigger.sv
module rxdd_trigger #(
  parameter int FWW = 10,
  parameter int THW = 5
) (
  input  logic [FWW-1:0] fifo_words,
  input  logic           fifo_frame_ready,
  input  logic [THW-1:0] cfg_thr,
  output logic           drain_go
);
  localparam int CW = (FWW > THW + 1) ? FWW : THW + 1;
  logic [CW-1:0] have_w, need_w;
  assign have_w   = CW'(fifo_words);
  assign need_w   = CW'({cfg_thr, 1'b0});
  assign drain_go = (fifo_words != '0) && (fifo_frame_ready || (have_w >= need_w));
endmodule

// File: rtl/rxdd_desc_cache.sv
module rxdd_desc_cache
  import rxdd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_link,
  input  logic           cap_cmd,
  input  logic           cap_buf,
  input  logic [31:0]    rdata,
  input  logic           word_done,
  input  logic [2:0]     word_bytes,
  output logic [AW-1:0]  link,
  output logic           own,
  output logic [AW-1:0]  buf_ptr,
  output logic [SZW-1:0] buf_left,
  output logic [SZW-1:0] stored,
  output logic           buf_last
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^rdata[30:SZW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link     <= '0;
      own      <= 1'b0;
      buf_ptr  <= '0;
      buf_left <= '0;
      stored   <= '0;
    end else begin
      if (cap_link) link <= rdata[AW-1:0];
      if (cap_buf) buf_ptr <= rdata[AW-1:0];
      if (cap_cmd) begin
        own      <= rdata[31];
        buf_left <= rdata[SZW-1:0];
        stored   <= '0;
      end else if (word_done) begin
        stored   <= stored + SZW'(word_bytes);
        buf_left <= (buf_left > SZW'(4)) ? buf_left - SZW'(4) : '0;
      end
    end
  end

  assign buf_last = (buf_left <= SZW'(4));
endmodule

// File: rtl/rxdd_burst_ctr.sv
module rxdd_burst_ctr
  import rxdd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       inc,
  input  logic [2:0] code,
  output logic       burst_end
);
  logic [7:0] cnt;
  logic [8:0] nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 8'd1;
  end

  assign nxt       = {1'b0, cnt} + 9'd1;
  assign burst_end = (nxt >= {1'b0, burst_limit(code)});
endmodule

// File: rtl/rx_drain_dma.sv
module rx_drain_dma
  import rxdd_pkg::*;
#(
  parameter int AW  = 32,
  parameter int FWW = 10,
  parameter int THW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en_cmd,
  input  logic           desc_dirty,
  input  logic [AW-1:0]  desc_head,
  input  logic [THW-1:0] cfg_thr,
  input  logic [2:0]     cfg_burst,
  input  logic [FWW-1:0] fifo_words,
  input  logic           fifo_frame_ready,
  input  logic [31:0]    fifo_data,
  input  logic           fifo_last,
  input  logic [2:0]     fifo_last_bytes,
  output logic           fifo_pop,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [31:0]    bus_wdata,
  input  logic [31:0]    bus_rdata,
  input  logic           bus_done,
  output logic           idle
);
  rxdd_state_e state_q, state_d;
  logic [1:0]    idx_q, idx_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          more_q, more_d;

  logic [AW-1:0]  link, buf_ptr;
  logic [SZW-1:0] buf_left, stored;
  logic           own, buf_last, drain_go, burst_end;

  // named events
  logic in_frag, in_block, in_dread, word_done, cap_link, cap_cmd, cap_buf;
  logic [2:0] word_bytes;
  assign in_frag    = (state_q == S_FRAG);
  assign in_block   = (state_q == S_BLOCK);
  assign in_dread   = (state_q == S_DREAD);
  assign word_done  = in_frag && bus_done;
  assign cap_link   = bus_done && ((state_q == S_REFRESH) || (in_dread && idx_q == 2'd0));
  assign cap_cmd    = bus_done && in_dread && (idx_q == 2'd1);
  assign cap_buf    = bus_done && in_dread && (idx_q == 2'd2);
  assign word_bytes = fifo_last ? fifo_last_bytes : 3'd4;

  rxdd_trigger #(.FWW(FWW), .THW(THW)) u_trig (
    .fifo_words(fifo_words), .fifo_frame_ready(fifo_frame_ready),
    .cfg_thr(cfg_thr), .drain_go(drain_go));

  rxdd_desc_cache #(.AW(AW)) u_cache (
    .clk(clk), .rst_n(rst_n), .cap_link(cap_link), .cap_cmd(cap_cmd),
    .cap_buf(cap_buf), .rdata(bus_rdata), .word_done(word_done),
    .word_bytes(word_bytes), .link(link), .own(own), .buf_ptr(buf_ptr),
    .buf_left(buf_left), .stored(stored), .buf_last(buf_last));

  rxdd_burst_ctr u_burst (
    .clk(clk), .rst_n(rst_n), .clr(in_block), .inc(word_done),
    .code(cfg_burst), .burst_end(burst_end));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    more_d  = more_q;
    unique case (state_q)
      S_IDLE: if (rx_en_cmd) begin
        ptr_d   = desc_head;
        idx_d   = 2'd0;
        state_d = desc_dirty ? S_REFRESH : S_DREAD;
      end
      S_REFRESH: if (bus_done) state_d = S_ADV;
      S_DREAD: if (bus_done) begin
        if (idx_q == 2'd2) begin
          idx_d   = 2'd0;
          state_d = own ? S_BLOCK : S_IDLE;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      S_BLOCK: begin
        if (buf_left == '0) begin
          more_d  = 1'b1;
          state_d = S_DWRITE;
        end else if (drain_go) begin
          state_d = S_FRAG;
        end
      end
      S_FRAG: if (bus_done) begin
        if (fifo_last) begin
          more_d  = 1'b0;
          state_d = S_DWRITE;
        end else if (buf_last) begin
          more_d  = 1'b1;
          state_d = S_DWRITE;
        end else if (burst_end || fifo_words <= FWW'(1)) begin
          state_d = S_BLOCK;
        end
      end
      S_DWRITE: if (bus_done) state_d = S_ADV;
      S_ADV: begin
        if (link != '0) begin
          ptr_d   = link;
          idx_d   = 2'd0;
          state_d = S_DREAD;
        end else begin
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      more_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      more_q  <= more_d;
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state_q)
      S_REFRESH: begin
        bus_req  = 1'b1;
        bus_addr = ptr_q;
      end
      S_DREAD: begin
        bus_req  = 1'b1;
        bus_addr = ptr_q + AW'({idx_q, 2'b00});
      end
      S_FRAG: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = buf_ptr + AW'(stored);
        bus_wdata = fifo_data;
      end
      S_DWRITE: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = ptr_q + AW'(4);
        bus_wdata = wb_word(more_q, stored);
      end
      default: ;
    endcase
  end

  assign fifo_pop = word_done;
  assign idle     = (state_q == S_IDLE);
endmodule

// File: rtl/rx_drain_dma_chk.sv
module rx_drain_dma_chk #(
  parameter int AW  = 32,
  parameter int FWW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     cfg_burst,
  input logic [FWW-1:0] fifo_words,
  input logic           fifo_pop,
  input logic           bus_req,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_done,
  input logic           idle,
  input logic           in_frag,
  input logic           drain_go,
  input logic           word_done
);
  logic [8:0] seen;
  logic [8:0] lim;
  assign lim = (cfg_burst == 3'd0) ? 9'd128 : (9'd1 << cfg_burst) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= '0;
    else if (!in_frag) seen <= '0;
    else if (word_done) seen <= seen + 9'd1;
  end

  // R4
  a_r4_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_words != '0);
  // R4
  a_r4_drain_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frag && !$past(in_frag)) |-> $past(drain_go));
  // R5
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= lim);
  // R6
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  // R6
  a_r6_pop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (bus_done && bus_we));
  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !bus_req);
endmodule

bind rx_drain_dma rx_drain_dma_chk #(.AW(AW), .FWW(FWW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .fifo_words(fifo_words),
  .fifo_pop(fifo_pop), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_done(bus_done), .idle(idle), .in_frag(in_frag), .drain_go(drain_go),
  .word_done(word_done));

// File: tb/rx_drain_dma_tb_top.sv
`timescale 1ns/1ps
module rx_drain_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rx_en_cmd = 1'b0, desc_dirty = 1'b0;
  logic [31:0] desc_head = '0;
  logic [4:0]  cfg_thr = '0;
  logic [2:0]  cfg_burst = '0;
  logic [9:0]  fifo_words;
  logic        fifo_frame_ready, fifo_last, fifo_pop;
  logic [31:0] fifo_data;
  logic [2:0]  fifo_last_bytes;
  logic        bus_req, bus_we, bus_done, idle;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  // FIFO model
  logic [31:0] fq_data [0:255];
  logic        fq_last [0:255];
  logic [2:0]  fq_lb   [0:255];
  int wr_ptr = 0, rd_ptr = 0, frames_in = 0, frames_out = 0;
  assign fifo_words       = 10'(wr_ptr - rd_ptr);
  assign fifo_frame_ready = (frames_in != frames_out);
  assign fifo_data        = fq_data[rd_ptr[7:0]];
  assign fifo_last        = fq_last[rd_ptr[7:0]] && (wr_ptr != rd_ptr);
  assign fifo_last_bytes  = fq_lb[rd_ptr[7:0]];

  logic [31:0] mem [0:2047];
  int n_chk = 0, n_bad = 0;
  int rd_n, wr_n, data_n, gap_n;
  logic [31:0] rd_log [0:15];
  logic prev_req, pop_pend, w;
  logic [31:0] a, d;
  bit done_flag = 0;

  rx_drain_dma dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en_cmd(rx_en_cmd), .desc_dirty(desc_dirty),
    .desc_head(desc_head), .cfg_thr(cfg_thr), .cfg_burst(cfg_burst),
    .fifo_words(fifo_words), .fifo_frame_ready(fifo_frame_ready),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_last_bytes(fifo_last_bytes),
    .fifo_pop(fifo_pop), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done), .idle(idle));

  // host memory model: done one cycle after the request is seen
  initial begin : host_model
    prev_req = 0; pop_pend = 0; bus_done = 0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_done = 0;
      if (pop_pend) begin
        if (fq_last[rd_ptr[7:0]]) frames_out++;
        rd_ptr++;
        pop_pend = 0;
      end
      #1;
      if (bus_req === 1'b1) begin
        a = bus_addr; w = bus_we; d = bus_wdata;
        if (w) begin
          wr_n++;
          mem[a[12:2]] = d;
          if (a >= 32'h1000) begin
            data_n++;
            if (!prev_req) gap_n++;
          end
        end else begin
          if (rd_n < 16) rd_log[rd_n] = a;
          rd_n++;
        end
        @(negedge clk);
        bus_rdata = w ? '0 : mem[a[12:2]];
        bus_done = 1;
        #1 pop_pend = fifo_pop;
        prev_req = 1;
      end else begin
        prev_req = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wb(input logic more, input int size);
    return {1'b0, more, 18'b0, size[11:0]};
  endfunction

  task automatic clr_log();
    rd_n = 0; wr_n = 0; data_n = 0; gap_n = 0;
  endtask

  task automatic set_desc(input int ad, input int lnk, input logic own, input int sz, input int bp);
    mem[ad >> 2]       = lnk;
    mem[(ad >> 2) + 1] = {own, 19'b0, sz[11:0]};
    mem[(ad >> 2) + 2] = bp;
  endtask

  task automatic push_frame(input int n, input int lb, input int seed, input bit close);
    for (int i = 0; i < n; i++) begin
      fq_data[wr_ptr[7:0]] = (seed << 16) | i;
      fq_last[wr_ptr[7:0]] = close && (i == n - 1);
      fq_lb[wr_ptr[7:0]]   = 3'(lb);
      wr_ptr++;
      if (close && i == n - 1) frames_in++;
    end
  endtask

  task automatic start(input int head, input logic dirty);
    @(negedge clk);
    desc_head = head; desc_dirty = dirty; rx_en_cmd = 1;
    @(negedge clk);
    rx_en_cmd = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (!idle && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic chk_buf(input string req, input int bp, input int seed, input int first, input int cnt);
    for (int k = 0; k < cnt; k++)
      chk(req, mem[(bp >> 2) + k], (seed << 16) | (first + k));
  endtask

  // R1
  task automatic t_reset();
    chk("R1 idle", 32'(idle), 1);
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 fifo_pop", 32'(fifo_pop), 0);
  endtask

  // R2 R6 R8 R9: single buffer, full burst
  task automatic t_basic();
    clr_log();
    set_desc(32'h100, 0, 1, 64, 32'h1000);
    cfg_thr = 0; cfg_burst = 0;
    push_frame(5, 2, 1, 1);
    start(32'h100, 0);
    wait_idle();
    chk("R2 read0", rd_log[0], 32'h100);
    chk("R2 read1", rd_log[1], 32'h104);
    chk("R2 read2", rd_log[2], 32'h108);
    chk_buf("R6 data", 32'h1000, 1, 0, 5);
    chk("R8 status", mem[32'h104 >> 2], exp_wb(0, 18));
    chk("R5 one burst", gap_n, 1);
    chk("R9 idle on null link", 32'(idle), 1);
  endtask

  // R7 R8: frame over three descriptors
  task automatic t_chain();
    clr_log();
    set_desc(32'h200, 32'h210, 1, 16, 32'h1100);
    set_desc(32'h210, 32'h220, 1, 16, 32'h1200);
    set_desc(32'h220, 0, 1, 64, 32'h1300);
    cfg_thr = 0; cfg_burst = 0;
    push_frame(10, 3, 2, 1);
    start(32'h200, 0);
    wait_idle();
    chk_buf("R7 buf1", 32'h1100, 2, 0, 4);
    chk_buf("R7 buf2", 32'h1200, 2, 4, 4);
    chk_buf("R7 buf3", 32'h1300, 2, 8, 2);
    chk("R7 status1", mem[32'h204 >> 2], exp_wb(1, 16));
    chk("R7 status2", mem[32'h214 >> 2], exp_wb(1, 16));
    chk("R8 status3", mem[32'h224 >> 2], exp_wb(0, 7));
  endtask

  // R5: burst length codes
  task automatic t_burst(input logic [2:0] code, input int n, input int exp_gaps, input int seed);
    clr_log();
    set_desc(32'h500, 0, 1, 64, 32'h1600);
    cfg_thr = 0; cfg_burst = code;
    push_frame(n, 4, seed, 1);
    start(32'h500, 0);
    wait_idle();
    chk("R5 bursts", gap_n, exp_gaps);
    chk("R5 words", data_n, n);
    chk_buf("R6 burst data", 32'h1600, seed, 0, n);
    chk("R8 burst status", mem[32'h504 >> 2], exp_wb(0, 4 * n));
  endtask

  // R4: threshold gate
  task automatic t_thresh();
    clr_log();
    set_desc(32'h600, 0, 1, 64, 32'h1700);
    cfg_thr = 4; cfg_burst = 0;
    start(32'h600, 0);
    @(negedge clk);
    push_frame(5, 4, 4, 0);
    repeat (20) @(negedge clk);
    chk("R4 below threshold", data_n, 0);
    push_frame(3, 4, 5, 0);
    repeat (30) @(negedge clk);
    chk("R4 at threshold", data_n, 8);
    push_frame(1, 1, 6, 1);
    wait_idle();
    chk("R4 frame end drains", data_n, 9);
    chk("R8 thresh status", mem[32'h604 >> 2], exp_wb(0, 33));
  endtask

  // R3: descriptor not available
  task automatic t_not_owned();
    clr_log();
    set_desc(32'h400, 0, 0, 64, 32'h1500);
    mem[32'h404 >> 2] = 32'h0000_0040;
    start(32'h400, 0);
    wait_idle();
    chk("R3 reads", rd_n, 3);
    chk("R3 no writes", wr_n, 0);
    chk("R3 control untouched", mem[32'h404 >> 2], 32'h0000_0040);
  endtask

  // R2 R9: dirty head, two frames into two descriptors
  task automatic t_dirty();
    clr_log();
    set_desc(32'h300, 32'h310, 0, 0, 0);
    set_desc(32'h310, 32'h320, 1, 64, 32'h1400);
    set_desc(32'h320, 0, 1, 64, 32'h1480);
    cfg_thr = 0; cfg_burst = 0;
    push_frame(3, 4, 7, 1);
    start(32'h300, 1);
    repeat (60) @(negedge clk);
    desc_dirty = 0;
    chk("R9 waits on next desc", 32'(idle), 0);
    push_frame(2, 1, 8, 1);
    wait_idle();
    chk("R2 dirty first read", rd_log[0], 32'h300);
    chk("R2 dirty follows link", rd_log[1], 32'h310);
    chk("R9 next desc read", rd_log[4], 32'h320);
    chk("R2 read count", rd_n, 7);
    chk("R8 frame1 status", mem[32'h314 >> 2], exp_wb(0, 12));
    chk("R9 frame2 status", mem[32'h324 >> 2], exp_wb(0, 5));
    chk_buf("R9 frame2 data", 32'h1480, 8, 0, 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    for (int i = 0; i < 256; i++) begin fq_data[i] = '0; fq_last[i] = 0; fq_lb[i] = 3'd4; end
    clr_log();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chain();
    t_burst(3'd2, 6, 3, 9);
    t_burst(3'd1, 3, 3, 10);
    t_burst(3'd0, 8, 1, 11);
    t_thresh();
    t_not_owned();
    t_dirty();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule